// File: doc/BRIEF.md
# Multi-Size Associative Address Translator

This block turns a 32-bit virtual address into a 29-bit physical address by searching a fully associative table of sixteen translation entries in one step. Every entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, and valid, shared, dirty and two-bit protection fields. All entries are compared at once. The block flags a lookup that lands on more than one entry, checks the access against the entry's rights for the current privilege level and direction, and returns either a physical address or a fault code.

Two address windows skip the table altogether and are reachable only from privileged code. A global enable can turn translation off, which maps every address straight to its low 29 bits. Entries are written through a plain indexed write port, one entry per cycle. Refill and victim choice belong to software or to a neighbouring block.

Each request is a single-cycle pulse on `req_i`. The result is registered and shows up with `rsp_valid_o` on the following cycle.

Top module: `mtlb_lookup`

## Requirements
- R1: While `rst_ni` is low, `rsp_valid_o`, `hit_o`, `fault_o` and `paddr_o` are all zero, and every table entry is invalid.
- R2: A request sampled at a rising edge gives `rsp_valid_o`=1 for exactly the next cycle. `hit_o`=1 exactly when `fault_o`=0, and `paddr_o` is meaningful only when `hit_o`=1.
- R3: The size code maps 0 to 1 KB, 1 to 4 KB, 2 to 64 KB and 3 to 1 MB. The page match and the physical base both ignore the entry's VPN and PPN bits that fall below the page size. `paddr_o` is the masked PPN shifted left by 10, ORed with the address offset within the page.
- R4: An entry whose valid bit is 0 never matches. A write on the port replaces the whole entry at `wr_idx_i`.
- R5: The tag `asid_i` is compared only when `priv_i`=0 and `single_virt_i`=0. An entry with its shared bit set matches any tag.
- R6: A translated lookup that matches more than one entry gives fault 0x140.
- R7: A data lookup that matches no entry gives 0x040 for a read and 0x060 for a write.
- R8: The data protection code works as follows. 0 allows privileged reads only. 1 allows privileged reads and writes. 2 allows reads in both modes. 3 allows everything. A denied read gives 0x0A0 and a denied write gives 0x0C0.
- R9: A write that the protection allows, to an entry whose dirty bit is 0, gives fault 0x080.
- R10: When `fetch_i`=1, the access counts as a read: `write_i` and the dirty bit have no effect. A user-mode fetch from an entry whose protection bit 1 is clear gives 0x0A0. A fetch that matches no entry gives 0x040.
- R11: Addresses 0x80000000 to 0xBFFFFFFF, and 0xFC000000 upward, are not translated. In privileged mode they hit with `paddr_o` equal to the low 29 address bits, whatever the table holds and whatever `xlate_en_i` is.
- R12: A user-mode access to either untranslated window gives 0x060 for a data write and 0x040 otherwise.
- R13: With `xlate_en_i`=0, an address outside the untranslated windows hits with `paddr_o` equal to its low 29 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table entry |
| wr_idx_i | input | 4 | Entry index to write |
| wr_vpn_i | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn_i | input | 19 | Physical page number (address bits 28:10) |
| wr_size_i | input | 2 | Page size code |
| wr_asid_i | input | 8 | Address-space tag of the entry |
| wr_valid_i | input | 1 | Entry valid |
| wr_shared_i | input | 1 | Entry matches any tag |
| wr_dirty_i | input | 1 | Page already written |
| wr_prot_i | input | 2 | Protection code |
| req_i | input | 1 | Lookup request pulse |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 = write access |
| fetch_i | input | 1 | 1 = instruction fetch |
| asid_i | input | 8 | Current address-space tag |
| priv_i | input | 1 | Privileged mode |
| single_virt_i | input | 1 | Single-address-space mode (tag ignored) |
| xlate_en_i | input | 1 | Translation enable |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 12 | Fault code, 0 on success |
| paddr_o | output | 29 | Physical address |

## Verification
The hardest case to reach from the ports is a pair of entries with the same page that differ only in their tag. Whether they collide depends on the mode inputs, not on the address. The stimulus loads such a pair and sends the same address first as a tagged user read, which must resolve to one entry, and then as a privileged read, which must report the multiple-hit fault. A second pair at different sizes covers the same address, so the overlap check is also exercised across page sizes.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 29;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PPN_W  = PA_W - PG_LSB;
  localparam int ASID_W = 8;
  localparam int FLT_W  = 12;

  localparam logic [FLT_W-1:0] FLT_NONE   = 12'h000;
  localparam logic [FLT_W-1:0] FLT_MISS_R = 12'h040;
  localparam logic [FLT_W-1:0] FLT_MISS_W = 12'h060;
  localparam logic [FLT_W-1:0] FLT_INIT_W = 12'h080;
  localparam logic [FLT_W-1:0] FLT_PROT_R = 12'h0A0;
  localparam logic [FLT_W-1:0] FLT_PROT_W = 12'h0C0;
  localparam logic [FLT_W-1:0] FLT_MULTI  = 12'h140;

  typedef enum logic [1:0] {
    PG_1K   = 2'd0,
    PG_4K   = 2'd1,
    PG_64K  = 2'd2,
    PG_1M   = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_ent_t;

  // Bits of the page number kept by a page of the given size
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
    logic [VPN_W-1:0] ones;
    ones = '1;
    case (pg_size_e'(sz))
      PG_1K:   vpn_keep = ones;
      PG_4K:   vpn_keep = ones << 2;
      PG_64K:  vpn_keep = ones << 6;
      default: vpn_keep = ones << 10;
    endcase
  endfunction

  // Offset mask within the page, over a full physical address
  function automatic logic [PA_W-1:0] pa_offset(input logic [1:0] sz);
    logic [PA_W-1:0] ones;
    ones = '1;
    case (pg_size_e'(sz))
      PG_1K:   pa_offset = ~(ones << 10);
      PG_4K:   pa_offset = ~(ones << 12);
      PG_64K:  pa_offset = ~(ones << 16);
      default: pa_offset = ~(ones << 20);
    endcase
  endfunction
endpackage

// File: rtl/mtlb_store.sv
module mtlb_store
  import mtlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_ent_t         wr_ent_i,
  output tlb_ent_t         ent_o [N_ENTRIES]
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        ent_o[g] <= wr_ent_i;
      end
    end
  end
endmodule

// File: rtl/mtlb_match.sv
module mtlb_match
  import mtlb_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  tlb_ent_t          ent_i [N_ENTRIES],
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              use_asid_i,
  output logic [N_ENTRIES-1:0] hit_vec_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic asid_ok;
    logic page_ok;
    assign asid_ok = !use_asid_i || ent_i[g].shared || (ent_i[g].asid == asid_i);
    assign page_ok = ((vpn_i ^ ent_i[g].vpn) & vpn_keep(ent_i[g].size)) == '0;
    assign hit_vec_o[g] = ent_i[g].valid && asid_ok && page_ok;
  end
endmodule

// File: rtl/mtlb_resolve.sv
module mtlb_resolve
  import mtlb_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  tlb_ent_t             ent_i [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] hit_vec_i,
  input  logic [VA_W-1:0]      vaddr_i,
  input  logic                 write_i,
  input  logic                 fetch_i,
  input  logic                 priv_i,
  output logic [FLT_W-1:0]     fault_o,
  output logic [PA_W-1:0]      paddr_o
);
  localparam int ENT_W = $bits(tlb_ent_t);

  logic [ENT_W-1:0] sel_bits;
  tlb_ent_t         sel;
  logic             any_hit;
  logic             multi_hit;
  logic             eff_wr;
  logic [PA_W-1:0]  off_mask;
  logic [PA_W-1:0]  base;

  // Hit vector is one-hot when used, so an OR-mux picks the entry
  always_comb begin
    sel_bits = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec_i[i]) sel_bits = sel_bits | ENT_W'(ent_i[i]);
    end
  end
  assign sel = tlb_ent_t'(sel_bits);

  assign any_hit   = |hit_vec_i;
  assign multi_hit = $countones(hit_vec_i) > 1;
  assign eff_wr    = write_i && !fetch_i;
  assign off_mask  = pa_offset(sel.size);
  assign base      = {sel.ppn, {PG_LSB{1'b0}}};
  assign paddr_o   = (base & ~off_mask) | (vaddr_i[PA_W-1:0] & off_mask);

  always_comb begin
    if (multi_hit) begin
      fault_o = FLT_MULTI;
    end else if (!any_hit) begin
      fault_o = eff_wr ? FLT_MISS_W : FLT_MISS_R;
    end else if (fetch_i) begin
      fault_o = (!priv_i && !sel.prot[1]) ? FLT_PROT_R : FLT_NONE;
    end else if (!priv_i && !sel.prot[1]) begin
      fault_o = eff_wr ? FLT_PROT_W : FLT_PROT_R;
    end else if (eff_wr && !sel.prot[0]) begin
      fault_o = FLT_PROT_W;
    end else if (eff_wr && !sel.dirty) begin
      fault_o = FLT_INIT_W;
    end else begin
      fault_o = FLT_NONE;
    end
  end
endmodule

// File: rtl/mtlb_lookup.sv
module mtlb_lookup
  import mtlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [21:0]       wr_vpn_i,
  input  logic [18:0]       wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic [7:0]        wr_asid_i,
  input  logic              wr_valid_i,
  input  logic              wr_shared_i,
  input  logic              wr_dirty_i,
  input  logic [1:0]        wr_prot_i,
  input  logic              req_i,
  input  logic [31:0]       vaddr_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic [7:0]        asid_i,
  input  logic              priv_i,
  input  logic              single_virt_i,
  input  logic              xlate_en_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [11:0]       fault_o,
  output logic [28:0]       paddr_o
);
  tlb_ent_t             wr_ent;
  tlb_ent_t             ent [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit_vec;
  logic [FLT_W-1:0]     tr_fault;
  logic [PA_W-1:0]      tr_paddr;
  logic                 use_asid;
  logic                 in_bypass;
  logic [FLT_W-1:0]     fault_d;
  logic [PA_W-1:0]      paddr_d;

  assign wr_ent = '{valid: wr_valid_i, shared: wr_shared_i, dirty: wr_dirty_i,
                    prot: wr_prot_i, size: wr_size_i, asid: wr_asid_i,
                    vpn: wr_vpn_i, ppn: wr_ppn_i};

  mtlb_store #(.N_ENTRIES(N_ENTRIES)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_ent_i (wr_ent),
    .ent_o    (ent)
  );

  assign use_asid = !priv_i && !single_virt_i;

  mtlb_match #(.N_ENTRIES(N_ENTRIES)) i_match (
    .ent_i      (ent),
    .vpn_i      (vaddr_i[VA_W-1:PG_LSB]),
    .asid_i     (asid_i),
    .use_asid_i (use_asid),
    .hit_vec_o  (hit_vec)
  );

  mtlb_resolve #(.N_ENTRIES(N_ENTRIES)) i_resolve (
    .ent_i     (ent),
    .hit_vec_i (hit_vec),
    .vaddr_i   (vaddr_i),
    .write_i   (write_i),
    .fetch_i   (fetch_i),
    .priv_i    (priv_i),
    .fault_o   (tr_fault),
    .paddr_o   (tr_paddr)
  );

  assign in_bypass = (vaddr_i[31:30] == 2'b10) || (vaddr_i[31:26] == 6'h3F);

  always_comb begin
    paddr_d = vaddr_i[PA_W-1:0];
    if (in_bypass) begin
      fault_d = priv_i ? FLT_NONE : ((write_i && !fetch_i) ? FLT_MISS_W : FLT_MISS_R);
    end else if (!xlate_en_i) begin
      fault_d = FLT_NONE;
    end else begin
      fault_d = tr_fault;
      paddr_d = tr_paddr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      fault_o     <= '0;
      paddr_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        hit_o   <= (fault_d == FLT_NONE);
        fault_o <= fault_d;
        paddr_o <= (fault_d == FLT_NONE) ? paddr_d : '0;
      end
    end
  end
endmodule

// File: rtl/mtlb_lookup_chk.sv
module mtlb_lookup_chk #(
  parameter int N_ENTRIES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic [31:0]          vaddr_i,
  input logic                 write_i,
  input logic                 fetch_i,
  input logic                 priv_i,
  input logic                 xlate_en_i,
  input logic [N_ENTRIES-1:0] hit_vec,
  input logic                 rsp_valid_o,
  input logic                 hit_o,
  input logic [11:0]          fault_o,
  input logic [28:0]          paddr_o
);
  logic bypass_win;
  assign bypass_win = (vaddr_i[31:30] == 2'b10) || (vaddr_i[31:26] == 6'h3F);

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!rsp_valid_o && !hit_o && fault_o == '0); // R1
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R2

  AST_HIT_IFF_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (hit_o == (fault_o == 12'h000))); // R2

  AST_MULTI_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && xlate_en_i && !bypass_win && $countones(hit_vec) > 1)
      |=> fault_o == 12'h140); // R6

  AST_BYPASS_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bypass_win && priv_i)
      |=> hit_o && paddr_o == $past(vaddr_i[28:0])); // R11

  AST_BYPASS_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bypass_win && !priv_i)
      |=> fault_o == (($past(write_i) && !$past(fetch_i)) ? 12'h060 : 12'h040)); // R12

  AST_XLATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xlate_en_i && !bypass_win)
      |=> hit_o && paddr_o == $past(vaddr_i[28:0])); // R13
endmodule

bind mtlb_lookup mtlb_lookup_chk #(.N_ENTRIES(N_ENTRIES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .vaddr_i     (vaddr_i),
  .write_i     (write_i),
  .fetch_i     (fetch_i),
  .priv_i      (priv_i),
  .xlate_en_i  (xlate_en_i),
  .hit_vec     (hit_vec),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .fault_o     (fault_o),
  .paddr_o     (paddr_o)
);

// File: tb/test_mtlb_lookup.sv
module test_mtlb_lookup;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [21:0] wr_vpn = '0;
  logic [18:0] wr_ppn = '0;
  logic [1:0]  wr_size = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_valid = 1'b0, wr_shared = 1'b0, wr_dirty = 1'b0;
  logic [1:0]  wr_prot = '0;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic        wr_acc = 1'b0, fetch = 1'b0;
  logic [7:0]  asid = '0;
  logic        priv = 1'b0, sv = 1'b0, xen = 1'b1;
  logic        rsp_valid, hit;
  logic [11:0] fault;
  logic [28:0] paddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [11:0] flt;
    logic [28:0] pa;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  mtlb_lookup i_mtlb_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_ppn_i(wr_ppn),
    .wr_size_i(wr_size), .wr_asid_i(wr_asid), .wr_valid_i(wr_valid),
    .wr_shared_i(wr_shared), .wr_dirty_i(wr_dirty), .wr_prot_i(wr_prot),
    .req_i(req), .vaddr_i(vaddr), .write_i(wr_acc), .fetch_i(fetch),
    .asid_i(asid), .priv_i(priv), .single_virt_i(sv), .xlate_en_i(xen),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .fault_o(fault), .paddr_o(paddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic load(input int idx, input logic [21:0] vpn, input logic [18:0] ppn,
                      input logic [1:0] sz, input logic [7:0] as, input logic v,
                      input logic sh, input logic d, input logic [1:0] pr);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_size = sz;
    wr_asid = as; wr_valid = v; wr_shared = sh; wr_dirty = d; wr_prot = pr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: one request, expected result pushed to the scoreboard
  task automatic lookup(input logic [31:0] va, input logic w, input logic f,
                        input logic [11:0] eflt, input logic [28:0] epa, input string tag);
    exp_t e;
    @(negedge clk);
    vaddr = va; wr_acc = w; fetch = f; req = 1'b1;
    e.flt = eflt; e.pa = epa; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected response fault=%h exp=none", fault);
      end else begin
        e = exp_q.pop_front();
        if (fault !== e.flt || hit !== (e.flt == 12'h000) ||
            (e.flt == 12'h000 && paddr !== e.pa)) begin
          bad++;
          $display("FAIL %s: hit=%b fault=%h pa=%h exp hit=%b fault=%h pa=%h",
                   e.tag, hit, fault, paddr, e.flt == 12'h000, e.flt, e.pa);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || hit !== 1'b0 || fault !== '0 || paddr !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs v=%b h=%b f=%h pa=%h exp 0", rsp_valid, hit, fault, paddr);
    end
    rst_n = 1'b1;

    // R1: table empty after reset
    asid = 8'd5; priv = 1'b1;
    lookup(32'h0001_0000, 0, 0, 12'h040, '0, "R1 empty table miss");

    // Entries
    load(0, 22'h40,   19'h800,  2'd0, 8'd5, 1, 0, 1, 2'd3);
    load(1, 22'hC05,  19'h5407, 2'd3, 8'd9, 1, 1, 0, 2'd3);
    load(2, 22'h1400, 19'h1C0,  2'd2, 8'd5, 1, 0, 1, 2'd0);
    load(3, 22'h1800, 19'h48C,  2'd1, 8'd5, 1, 0, 1, 2'd2);
    load(4, 22'h1C00, 19'h20,   2'd1, 8'd5, 1, 0, 1, 2'd1);
    load(5, 22'h2000, 19'h3,    2'd0, 8'd5, 0, 0, 1, 2'd3);
    load(6, 22'h2400, 19'h1,    2'd0, 8'd5, 1, 0, 1, 2'd3);
    load(7, 22'h2400, 19'h2,    2'd1, 8'd5, 1, 0, 1, 2'd3);
    load(8, 22'h2800, 19'h10,   2'd0, 8'd5, 1, 0, 1, 2'd3);
    load(9, 22'h2800, 19'h20,   2'd0, 8'd6, 1, 0, 1, 2'd3);

    priv = 1'b0; asid = 8'd5;
    lookup(32'h0001_0123, 0, 0, 12'h000, 29'h0020_0123, "R3 1KB user read");
    lookup(32'h0001_0523, 0, 0, 12'h040, '0, "R7 R3 past 1KB page read miss");
    lookup(32'h0001_0523, 1, 0, 12'h060, '0, "R7 write miss");
    asid = 8'd6;
    lookup(32'h0001_0123, 0, 0, 12'h040, '0, "R5 tag mismatch");
    sv = 1'b1;
    lookup(32'h0001_0123, 0, 0, 12'h000, 29'h0020_0123, "R5 single virt ignores tag");
    sv = 1'b0; priv = 1'b1;
    lookup(32'h0001_0123, 0, 0, 12'h000, 29'h0020_0123, "R5 priv ignores tag");
    priv = 1'b0; asid = 8'd2;
    lookup(32'h003A_BCDE, 0, 0, 12'h000, 29'h015A_BCDE, "R3 R5 1MB shared masked");
    lookup(32'h003A_BCDE, 1, 0, 12'h080, '0, "R9 first write clean page");
    lookup(32'h003A_BCDE, 1, 1, 12'h000, 29'h015A_BCDE, "R10 fetch ignores write and dirty");

    asid = 8'd5; priv = 1'b1;
    lookup(32'h0050_ABCD, 0, 0, 12'h000, 29'h0007_ABCD, "R3 R8 64KB prot0 priv read");
    lookup(32'h0050_ABCD, 1, 0, 12'h0C0, '0, "R8 prot0 priv write");
    lookup(32'h0050_ABCD, 0, 1, 12'h000, 29'h0007_ABCD, "R10 priv fetch prot0");
    priv = 1'b0;
    lookup(32'h0050_ABCD, 0, 0, 12'h0A0, '0, "R8 prot0 user read");
    lookup(32'h0050_ABCD, 0, 1, 12'h0A0, '0, "R10 user fetch prot bit1 clear");
    lookup(32'h0060_0ABC, 0, 0, 12'h000, 29'h0012_3ABC, "R3 R8 4KB prot2 user read");
    lookup(32'h0060_0ABC, 1, 0, 12'h0C0, '0, "R8 prot2 user write");
    lookup(32'h0070_0010, 0, 0, 12'h0A0, '0, "R8 prot1 user read");
    lookup(32'h0070_0010, 0, 1, 12'h0A0, '0, "R10 prot1 user fetch");
    priv = 1'b1;
    lookup(32'h0070_0010, 1, 0, 12'h000, 29'h0000_8010, "R8 prot1 priv write");

    // Invalid entry, then rewrite it
    lookup(32'h0080_0004, 0, 0, 12'h040, '0, "R4 invalid entry misses");
    lookup(32'h0080_0004, 0, 1, 12'h040, '0, "R10 fetch miss");
    load(5, 22'h2000, 19'h3, 2'd0, 8'd5, 1, 0, 1, 2'd3);
    lookup(32'h0080_0004, 0, 0, 12'h000, 29'h0000_0C04, "R4 rewritten entry hits");

    // Overlaps
    lookup(32'h0090_0000, 0, 0, 12'h140, '0, "R6 1KB and 4KB overlap");
    lookup(32'h00A0_0000, 0, 0, 12'h140, '0, "R6 priv sees both tags");
    priv = 1'b0;
    lookup(32'h00A0_0000, 0, 0, 12'h000, 29'h0000_4000, "R5 R6 tag picks one");

    // Untranslated windows
    priv = 1'b1;
    lookup(32'h8123_4567, 0, 0, 12'h000, 29'h0123_4567, "R11 low window");
    lookup(32'hBFFF_FFFF, 1, 0, 12'h000, 29'h1FFF_FFFF, "R11 low window top");
    lookup(32'hFF00_0010, 0, 0, 12'h000, 29'h1F00_0010, "R11 high window");
    lookup(32'hC000_0000, 0, 0, 12'h040, '0, "R11 C0000000 is translated");
    priv = 1'b0;
    lookup(32'h8000_0000, 0, 0, 12'h040, '0, "R12 user read low window");
    lookup(32'hFC00_0000, 1, 0, 12'h060, '0, "R12 user write high window");
    lookup(32'hFC00_0000, 1, 1, 12'h040, '0, "R12 user fetch high window");

    // Translation off
    xen = 1'b0;
    lookup(32'h1234_5678, 1, 0, 12'h000, 29'h1234_5678, "R13 off user write");
    lookup(32'hE123_4567, 0, 0, 12'h000, 29'h0123_4567, "R13 off upper address");
    lookup(32'h8000_0000, 0, 0, 12'h040, '0, "R12 window still guarded when off");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing responses=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule